// File: doc/BRIEF.md
# GPIO Port Register Bank

This block keeps the per-pin state of a four-pin general purpose I/O port: which pins drive, what value they drive, and whether each sampled input is inverted when it is read. A host-side controller reaches it through a small internal register bus. The bus has a 2-bit pointer, an 8-bit write data bus with a single-cycle write strobe, and an 8-bit read data bus that follows the pointer combinationally.

On the pad side, each pin supplies an input level and receives an output value and an output enable. Input levels pass through a two-flop synchronizer. The synchronized levels, after per-bit polarity correction, drive two things: the input read-back and a live output for the interrupt logic. Only the low four bits of each register hold state. The upper four bits read back as a fixed pattern that depends on the register.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the output register reads 0xFF, the polarity register reads 0x00 and the direction register reads 0xFF. All output enables are low and all pad output values are high.
- R2: Pointer 0 reads the input view. A write strobe with pointer 0 changes no register and leaves every read value and pad output unchanged.
- R3: Pointers 1 (output value), 2 (polarity) and 3 (direction) can be written and read. A write takes effect on the clock edge that samples the strobe, and only write data bits 3..0 are stored.
- R4: A direction bit of 1 makes the pin an input, so its output enable is low whatever the output value. A direction bit of 0 makes the pin an output, so its output enable is high.
- R5: Reading pointer 1 returns the stored output flops and not the pin level.
- R6: The input view shows the synchronized level of every pin, including pins set as outputs.
- R7: A polarity bit of 1 inverts the matching input bit in the read-back. A polarity bit of 0 passes the bit unchanged.
- R8: Read bits 7..4 are 1 for pointers 0, 1 and 3 and 0 for pointer 2, whatever was written to them.
- R9: A change on a pad input appears in the read-back after exactly two rising clock edges and not after one.
- R10: The interrupt-side output equals the synchronized input levels XOR the polarity register.
- R11: Holding the synchronous active-low reset low across a clock edge in mid-operation restores all register defaults from R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_ptr | input | 2 | Register pointer (0 input, 1 output, 2 polarity, 3 direction) |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_data | output | 8 | Read data for the register selected by reg_ptr |
| pad_in | input | 4 | Pin levels from the pads |
| pad_out | output | 4 | Output values to the pads |
| pad_oe | output | 4 | Output enables to the pads, high means drive |
| irq_level | output | 4 | Synchronized, polarity-corrected input levels for interrupt logic |

## Verification
The assertions watch four things on every cycle. A direction write lands on the enables one cycle later. A write aimed at the input pointer leaves the control flops untouched. An output-register write reads back the cycle after. The synchronizer output trails the pads by exactly its stage count. Some behaviour only the bench scenarios can show. This covers the fixed upper-bit patterns per pointer and the inversion of selected input bits. It also covers pins set as outputs still being visible on the input view, the one-edge-early sample that must not yet show a pad change, and defaults coming back after a reset in mid-run.

// File: rtl/gpio_regs_pkg.sv
// Package gpio_regs_pkg
// Shared pointer encoding for the GPIO port register bank.
// Assumes a 2-bit register pointer.
package gpio_regs_pkg;

    typedef enum logic [1:0] {
        PTR_IN  = 2'd0,
        PTR_OUT = 2'd1,
        PTR_POL = 2'd2,
        PTR_CFG = 2'd3
    } reg_ptr_e;

endpackage

// File: rtl/gpio_in_sync.sv
// Module gpio_in_sync
// Brings asynchronous pad levels into the clock domain through a chain of
// STAGES flops per pin. Assumes each pad bit is independent (no bus
// coherency is needed across pins). The flops clear on synchronous reset.
module gpio_in_sync #(
    parameter int PIN_W  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] pad_in,
    output logic [PIN_W-1:0] sync_in
);

    localparam int WARM_W = $clog2(STAGES + 1) + 1;

    logic [PIN_W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: capture raw pad levels
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= pad_in;
                end
            end else begin : g_next
                // Purpose: pass the level one stage further down the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_in = stage_q[STAGES-1];

    // Purpose: count cycles since reset so the latency check starts only once the chain is full
    logic [WARM_W-1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                     warm_q <= '0;
        else if (warm_q < WARM_W'(STAGES)) warm_q <= warm_q + 1'b1;
    end

    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == WARM_W'(STAGES)) |-> (sync_in == $past(pad_in, STAGES))); // R9

endmodule

// File: rtl/gpio_ctrl_regs.sv
// Module gpio_ctrl_regs
// Holds the output-value, polarity and direction flops of every pin.
// Assumes a single-cycle write strobe. Only the low PIN_W bits of the
// write data are stored. Writes with the input pointer are dropped.
module gpio_ctrl_regs
    import gpio_regs_pkg::*;
#(
    parameter int PIN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_ptr,
    input  logic [PIN_W-1:0] wr_val,
    output logic [PIN_W-1:0] out_q,
    output logic [PIN_W-1:0] pol_q,
    output logic [PIN_W-1:0] cfg_q
);

    // Purpose: decode the write strobe per register
    logic hit_out, hit_pol, hit_cfg;
    always_comb begin
        hit_out = wr_en && (wr_ptr == PTR_OUT);
        hit_pol = wr_en && (wr_ptr == PTR_POL);
        hit_cfg = wr_en && (wr_ptr == PTR_CFG);
    end

    // Purpose: output value flops, default all ones
    always_ff @(posedge clk) begin
        if (!rst_n)       out_q <= '1;
        else if (hit_out) out_q <= wr_val;
    end

    // Purpose: polarity flops, default pass-through
    always_ff @(posedge clk) begin
        if (!rst_n)       pol_q <= '0;
        else if (hit_pol) pol_q <= wr_val;
    end

    // Purpose: direction flops, default every pin an input
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= '1;
        else if (hit_cfg) cfg_q <= wr_val;
    end

    AST_INPUT_PTR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ptr == PTR_IN) |=> ($stable(out_q) && $stable(pol_q) && $stable(cfg_q))); // R2

    AST_RESET_DEFAULTS: assert property (@(posedge clk)
        !rst_n |=> (out_q == '1 && pol_q == '0 && cfg_q == '1)); // R11

endmodule

// File: rtl/gpio_rd_mux.sv
// Module gpio_rd_mux
// Forms the read word for the selected pointer. The low bits carry the
// register or the input view. The upper bits carry a fixed fill: zeros for
// the polarity register and ones for all others. Purely combinational.
module gpio_rd_mux
    import gpio_regs_pkg::*;
#(
    parameter int PIN_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic [1:0]        rd_ptr,
    input  logic [PIN_W-1:0]  in_view,
    input  logic [PIN_W-1:0]  out_q,
    input  logic [PIN_W-1:0]  pol_q,
    input  logic [PIN_W-1:0]  cfg_q,
    output logic [DATA_W-1:0] rd_data
);

    localparam int FILL_W = DATA_W - PIN_W;
    localparam logic [FILL_W-1:0] FILL_ONES  = '1;
    localparam logic [FILL_W-1:0] FILL_ZEROS = '0;

    // Purpose: select register contents and append the per-register fill
    always_comb begin
        case (rd_ptr)
            PTR_IN:  rd_data = {FILL_ONES,  in_view};
            PTR_OUT: rd_data = {FILL_ONES,  out_q};
            PTR_POL: rd_data = {FILL_ZEROS, pol_q};
            default: rd_data = {FILL_ONES,  cfg_q};
        endcase
    end

endmodule

// File: rtl/gpio_port_regs.sv
// Module gpio_port_regs
// Register bank of a GPIO port: synchronizes pad inputs, keeps the control
// flops, drives pad output values and enables, and returns read data.
// Assumes a synchronous active-low reset and a pointer-addressed register
// bus with a one-cycle write strobe.
module gpio_port_regs
    import gpio_regs_pkg::*;
#(
    parameter int PIN_W       = 4,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [PIN_W-1:0]  pad_in,
    output logic [PIN_W-1:0]  pad_out,
    output logic [PIN_W-1:0]  pad_oe,
    output logic [PIN_W-1:0]  irq_level
);

    logic [PIN_W-1:0] sync_in;
    logic [PIN_W-1:0] out_q, pol_q, cfg_q;
    logic [PIN_W-1:0] in_view;
    logic             unused_wr_upper;

    assign unused_wr_upper = ^wr_data[DATA_W-1:PIN_W];

    gpio_in_sync #(
        .PIN_W  (PIN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_in  (pad_in),
        .sync_in (sync_in)
    );

    gpio_ctrl_regs #(
        .PIN_W (PIN_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_ptr (reg_ptr),
        .wr_val (wr_data[PIN_W-1:0]),
        .out_q  (out_q),
        .pol_q  (pol_q),
        .cfg_q  (cfg_q)
    );

    // Purpose: polarity-correct the synchronized levels and drive the pads
    always_comb begin
        in_view   = sync_in ^ pol_q;
        irq_level = in_view;
        pad_out   = out_q;
        pad_oe    = ~cfg_q;
    end

    gpio_rd_mux #(
        .PIN_W  (PIN_W),
        .DATA_W (DATA_W)
    ) u_rd (
        .rd_ptr  (reg_ptr),
        .in_view (in_view),
        .out_q   (out_q),
        .pol_q   (pol_q),
        .cfg_q   (cfg_q),
        .rd_data (rd_data)
    );

    AST_CFG_WRITE_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_ptr == PTR_CFG) |=> (pad_oe == ~$past(wr_data[PIN_W-1:0]))); // R4

    AST_OUT_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_ptr == PTR_OUT) ##1 (reg_ptr == PTR_OUT)
        |-> (rd_data[PIN_W-1:0] == $past(wr_data[PIN_W-1:0]))); // R3

    AST_POL_CLEAR_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_q == '0) |-> (irq_level == sync_in)); // R10

endmodule

// File: tb/test_gpio_port_regs.sv
module test_gpio_port_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_ptr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] rd_data;
    logic [3:0] pad_in = 4'hA;
    logic [3:0] pad_out, pad_oe, irq_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int         kind;   // 0 rd_data, 1 pad_oe, 2 pad_out, 3 irq_level
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    gpio_port_regs i_gpio_port_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_ptr   (reg_ptr),
        .wr_data   (wr_data),
        .wr_en     (wr_en),
        .rd_data   (rd_data),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq_level (irq_level)
    );

    // Monitor: compares queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = rd_data;
                    1:       act = {4'h0, pad_oe};
                    2:       act = {4'h0, pad_out};
                    default: act = {4'h0, irq_level};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] p, input logic [7:0] d);
        reg_ptr = p; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_rd(input logic [1:0] p, input logic [7:0] e, input string r);
        reg_ptr = p;
        sb_q.push_back('{0, e, r});
        @(negedge clk);
    endtask

    task automatic expect_pins(input logic [3:0] oe, input logic [3:0] o,
                               input logic [3:0] irq, input string r);
        sb_q.push_back('{1, {4'h0, oe}, r});
        sb_q.push_back('{2, {4'h0, o}, r});
        sb_q.push_back('{3, {4'h0, irq}, r});
        @(negedge clk);
    endtask

    // Driver
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset defaults
        expect_rd(2'd1, 8'hFF, "R1 out default");
        expect_rd(2'd2, 8'h00, "R1 pol default");
        expect_rd(2'd3, 8'hFF, "R1 cfg default");
        expect_pins(4'h0, 4'hF, 4'hA, "R1 pins default");
        expect_rd(2'd0, 8'hFA, "R2 R8 input view");
        // R3 R8 output register, upper bits ignored
        wr(2'd1, 8'h35);
        expect_rd(2'd1, 8'hF5, "R3 R8 out readback");
        expect_pins(4'h0, 4'h5, 4'hA, "R4 inputs not driven");
        // R4 direction
        wr(2'd3, 8'h0C);
        expect_rd(2'd3, 8'hFC, "R3 cfg readback");
        expect_pins(4'h3, 4'h5, 4'hA, "R4 outputs enabled");
        // R7 polarity, R8 upper zeros
        wr(2'd2, 8'hA6);
        expect_rd(2'd2, 8'h06, "R3 R8 pol readback");
        expect_rd(2'd0, 8'hFC, "R7 inverted input");
        expect_pins(4'h3, 4'h5, 4'hC, "R10 irq corrected");
        // R2 write to input pointer dropped
        wr(2'd0, 8'h00);
        expect_rd(2'd0, 8'hFC, "R2 input unchanged");
        expect_rd(2'd1, 8'hF5, "R2 out unchanged");
        expect_rd(2'd2, 8'h06, "R2 pol unchanged");
        expect_rd(2'd3, 8'hFC, "R2 cfg unchanged");
        expect_pins(4'h3, 4'h5, 4'hC, "R2 pins unchanged");
        // R9 latency, R6 output pins visible (bits 0,1 are outputs)
        pad_in = 4'h9;
        @(negedge clk);
        expect_rd(2'd0, 8'hFC, "R9 one edge not yet");
        expect_rd(2'd0, 8'hFF, "R9 R6 two edges visible");
        // R5 output read is the flop, not the pin
        expect_rd(2'd1, 8'hF5, "R5 out flop readback");
        // R7 clear polarity passes input
        wr(2'd2, 8'h00);
        expect_rd(2'd0, 8'hF9, "R7 pass-through");
        expect_pins(4'h3, 4'h5, 4'h9, "R10 irq raw");
        // R4 back to inputs
        wr(2'd3, 8'hFF);
        expect_pins(4'h0, 4'h5, 4'h9, "R4 all inputs");
        // R11 reset mid-run
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h0F);
        wr(2'd3, 8'h00);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        expect_rd(2'd1, 8'hFF, "R11 out restored");
        expect_rd(2'd2, 8'h00, "R11 pol restored");
        expect_rd(2'd3, 8'hFF, "R11 cfg restored");
        expect_pins(4'h0, 4'hF, 4'h9, "R11 pins restored");
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule